// File: doc/BRIEF.md
# Audio Stream DMA Channel

This block is one direction of an audio DMA engine. It moves 32-bit words between system memory and a byte stream of 16-bit stereo samples. A parameter selects the direction. In the playback form the channel reads memory and hands each word to a sample sink. In the capture form it takes words from a sample source and writes them to memory.

Software loads a start address and a byte count while the channel is idle. Each service request then opens one pass. The request also carries the number of bytes the stream side can take or supply at that moment. A pass moves the smaller of that offer and the remaining count, split into chunks of bounded size. The pass stops early and keeps its progress when the stream side is not ready as a chunk begins. When a pass leaves the count at zero while the channel is enabled, a one-cycle completion pulse is raised. Stream words carry their first byte in bits 31:24, and each sample is big-endian.

Top module: `aud_dma_chan`

## Requirements
- R1: After reset the channel is idle. No memory request, no stream handshake signal and no interrupt is asserted, and the current address and count are both zero.
- R2: A load strobe in the idle state captures the address and the byte count, each with bits 1:0 cleared. A load strobe while a pass is running is ignored.
- R3: A pass moves exactly min(count, offer), with both values rounded down to a multiple of 4 bytes, provided the stream side never refuses a chunk.
- R4: A service request does nothing when the enable is low or when the rounded amount is zero. It raises no memory request and no interrupt.
- R5: A pass is split into chunks of at most CHUNK_BYTES. At the start of each chunk the stream side must be ready (sink ready in playback, source valid in capture). If it is not, the pass ends at once and keeps the words already moved.
- R6: A stall by the stream side inside a chunk makes the channel wait; it does not end the pass.
- R7: Each word that completes on both sides advances the address by 4 and lowers the count by 4. Words pass unchanged from ascending memory addresses to the stream.
- R8: The completion interrupt is a one-cycle pulse in the cycle after a pass ends. It is raised only if the enable is high and the count is zero at that point, so it never repeats while the count stays at zero.
- R9: Clearing the enable during a pass lets the word in flight complete. The channel then goes idle without an interrupt, and the address and count keep the progress made.
- R10: A memory request is held with a stable address until it is granted.
- R11: In playback, sink valid is held with stable data until the sink is ready.
- R12: In capture, source words are written unchanged to ascending memory addresses.
- R13: A service request that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| ld_stb | input | 1 | Load address and count |
| ld_addr | input | ADDR_W | Start byte address |
| ld_count | input | CNT_W | Byte count |
| svc_req | input | 1 | Service opportunity: start a pass |
| svc_avail | input | CNT_W | Bytes the stream side offers or can take |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (capture) / read (playback) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_gnt | input | 1 | Memory grant; completes the beat |
| mem_rdata | input | 32 | Memory read word, valid with grant |
| snk_valid | output | 1 | Playback word valid |
| snk_data | output | 32 | Playback word |
| snk_ready | input | 1 | Sink ready |
| src_valid | input | 1 | Capture word valid |
| src_data | input | 32 | Capture word |
| src_ready | output | 1 | Source ready |
| busy | output | 1 | Pass in progress |
| cur_addr | output | ADDR_W | Current byte address |
| cur_count | output | CNT_W | Remaining byte count |
| done_irq | output | 1 | Completion pulse |

## Verification
A wrong pass budget or chunk counter shows up at the ports when the pass ends, which is at most a few cycles after the last word. The remaining count, the final address and the number of stream words all differ from the expected min(count, offer). A fault in the sequencer's interrupt decision shows as a missing or extra pulse in the single cycle after busy falls. A corrupted data holding register shows up on the very next stream or memory word. Partial passes make some faults visible that a full pass would hide: an early stream refusal, a stall inside a chunk and an enable dropped mid-pass each leave a distinct non-zero count.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
   localparam int WORD_BYTES = 4;
   localparam int DATA_W     = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHK,
      ST_MEM,
      ST_STR,
      ST_FIN
   } dma_st_e;
endpackage

// File: rtl/aud_dma_wmin.sv
module aud_dma_wmin #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] min_o
);
   logic [W-1:0] a_w;
   logic [W-1:0] b_w;

   // both operands are cut down to whole 32-bit words before comparing
   assign a_w   = {a_i[W-1:2], 2'b00};
   assign b_w   = {b_i[W-1:2], 2'b00};
   assign min_o = (a_w < b_w) ? a_w : b_w;
endmodule

// File: rtl/aud_dma_ptr.sv
module aud_dma_ptr
   import aud_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [CNT_W-1:0]  ld_cnt_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              zero_o
);
   localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0]  C_STEP = CNT_W'(WORD_BYTES);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (ld_i) begin
         addr_q <= {ld_addr_i[ADDR_W-1:2], 2'b00};
         cnt_q  <= {ld_cnt_i[CNT_W-1:2], 2'b00};
      end else if (step_i) begin
         addr_q <= addr_q + A_STEP;
         cnt_q  <= cnt_q - C_STEP;
      end
   end

   assign addr_o = addr_q;
   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

   AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (cnt_q >= C_STEP)); // R7
endmodule

// File: rtl/aud_dma_seq.sv
module aud_dma_seq
   import aud_dma_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CHUNK_BYTES = 4096,
   parameter int PLAYBACK    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              svc_i,
   input  logic [CNT_W-1:0]  budget_i,
   input  logic              zero_i,
   input  logic              mem_gnt_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              snk_ready_i,
   input  logic              src_valid_i,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              snk_valid_o,
   output logic [DATA_W-1:0] snk_data_o,
   output logic              src_ready_o,
   output logic              busy_o,
   output logic              step_o,
   output logic              irq_o
);
   localparam bit             PLAY    = (PLAYBACK != 0);
   localparam logic [CNT_W-1:0] C_STEP  = CNT_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0] CHUNK_V = CNT_W'(CHUNK_BYTES);
   localparam dma_st_e        FIRST   = PLAY ? ST_MEM : ST_STR;
   localparam dma_st_e        SECOND  = PLAY ? ST_STR : ST_MEM;

   dma_st_e           st_q;
   logic [CNT_W-1:0]  pass_q;
   logic [CNT_W-1:0]  chunk_q;
   logic [DATA_W-1:0] buf_q;
   logic              irq_q;
   logic              hs;
   logic [DATA_W-1:0] in_word;
   logic              grab;
   logic              beat_end;

   // direction variant: which stream handshake counts and where words come from
   if (PLAY) begin : g_play
      logic unused_cap;
      assign hs          = snk_ready_i;
      assign in_word     = mem_rdata_i;
      assign snk_valid_o = (st_q == ST_STR);
      assign snk_data_o  = buf_q;
      assign src_ready_o = 1'b0;
      assign mem_we_o    = 1'b0;
      assign mem_wdata_o = '0;
      assign unused_cap  = ^{src_valid_i, src_data_i};
   end else begin : g_cap
      logic unused_play;
      assign hs          = src_valid_i;
      assign in_word     = src_data_i;
      assign snk_valid_o = 1'b0;
      assign snk_data_o  = '0;
      assign src_ready_o = (st_q == ST_STR);
      assign mem_we_o    = 1'b1;
      assign mem_wdata_o = buf_q;
      assign unused_play = ^{snk_ready_i, mem_rdata_i};
   end

   assign grab     = PLAY ? (st_q == ST_MEM && mem_gnt_i) : (st_q == ST_STR && hs);
   assign beat_end = PLAY ? (st_q == ST_STR && hs) : (st_q == ST_MEM && mem_gnt_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pass_q  <= '0;
         chunk_q <= '0;
         buf_q   <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (grab) buf_q <= in_word;
         if (beat_end) begin
            pass_q  <= pass_q - C_STEP;
            chunk_q <= chunk_q - C_STEP;
         end
         unique case (st_q)
            ST_IDLE: begin
               if (svc_i && en_i && budget_i != '0) begin
                  pass_q <= budget_i;
                  st_q   <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (!en_i || !hs) begin
                  st_q <= ST_FIN;
               end else begin
                  chunk_q <= (pass_q < CHUNK_V) ? pass_q : CHUNK_V;
                  st_q    <= FIRST;
               end
            end
            ST_MEM, ST_STR: begin
               if (grab) begin
                  st_q <= SECOND;
               end else if (beat_end) begin
                  if (pass_q == C_STEP || !en_i) st_q <= ST_FIN;
                  else if (chunk_q == C_STEP)    st_q <= ST_CHK;
                  else                           st_q <= FIRST;
               end
            end
            ST_FIN: begin
               irq_q <= en_i && zero_i;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o = (st_q == ST_MEM);
   assign busy_o    = (st_q != ST_IDLE);
   assign step_o    = beat_end;
   assign irq_o     = irq_q;

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R8
   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> zero_i); // R8
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_gnt_i) |=> mem_req_o); // R10
   AST_SNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid_o && !snk_ready_i) |=> (snk_valid_o && $stable(snk_data_o))); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_req_o && !snk_valid_o && !src_ready_o)); // R4
endmodule

// File: rtl/aud_dma_chan.sv
module aud_dma_chan
   import aud_dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter int CHUNK_BYTES = 4096,
   parameter int PLAYBACK    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [CNT_W-1:0]  ld_count,
   input  logic              svc_req,
   input  logic [CNT_W-1:0]  svc_avail,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   output logic              snk_valid,
   output logic [31:0]       snk_data,
   input  logic              snk_ready,
   input  logic              src_valid,
   input  logic [31:0]       src_data,
   output logic              src_ready,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic              done_irq
);
   if (CHUNK_BYTES < WORD_BYTES || (CHUNK_BYTES % WORD_BYTES) != 0) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a positive multiple of the word size");
   end
   if (CNT_W < 3 || CHUNK_BYTES >= (64'd1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for the chunk size");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end

   logic             step;
   logic             cnt_zero;
   logic [CNT_W-1:0] budget;
   logic             ld_ok;

   assign ld_ok = ld_stb && !busy;

   aud_dma_wmin #(.W(CNT_W)) i_budget (
      .a_i   (cur_count),
      .b_i   (svc_avail),
      .min_o (budget)
   );

   aud_dma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_i      (ld_ok),
      .ld_addr_i (ld_addr),
      .ld_cnt_i  (ld_count),
      .step_i    (step),
      .addr_o    (cur_addr),
      .cnt_o     (cur_count),
      .zero_o    (cnt_zero)
   );

   aud_dma_seq #(.CNT_W(CNT_W), .CHUNK_BYTES(CHUNK_BYTES), .PLAYBACK(PLAYBACK)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (chan_en),
      .svc_i       (svc_req),
      .budget_i    (budget),
      .zero_i      (cnt_zero),
      .mem_gnt_i   (mem_gnt),
      .mem_rdata_i (mem_rdata),
      .snk_ready_i (snk_ready),
      .src_valid_i (src_valid),
      .src_data_i  (src_data),
      .mem_req_o   (mem_req),
      .mem_we_o    (mem_we),
      .mem_wdata_o (mem_wdata),
      .snk_valid_o (snk_valid),
      .snk_data_o  (snk_data),
      .src_ready_o (src_ready),
      .busy_o      (busy),
      .step_o      (step),
      .irq_o       (done_irq)
   );

   assign mem_addr = cur_addr;

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> $stable(mem_addr)); // R10
   AST_LOAD_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb && busy && !step) |=> $stable(cur_count)); // R2
endmodule

// File: tb/test_aud_dma_chan.sv
`timescale 1ns/1ps
module test_aud_dma_chan;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, en, ld_stb, svc_req;
   logic [31:0] ld_addr;
   logic [15:0] ld_count, svc_avail;
   logic mem_req, mem_we, mem_gnt, snk_valid, snk_ready, busy, done_irq, p_src_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, snk_data, cur_addr;
   logic [15:0] cur_count;

   logic c_ld, c_svc, c_src_on, c_mem_req, c_mem_we, c_mem_gnt, c_src_ready, c_busy, c_irq;
   logic c_unused_valid;
   logic [31:0] c_ld_addr, c_mem_addr, c_mem_wdata, c_src_data, c_addr, c_unused_data;
   logic [15:0] c_ld_count, c_avail, c_count;

   int n_tests = 0, n_fail = 0, cyc = 0;
   int rx_n = 0, rx_lim = 0, stall_at = -1, hold = 0, snk_mode = 0;
   int irq_cnt = 0, c_irq_cnt = 0, c_k = 0;
   logic gnt_tog = 1'b0;
   logic [31:0] rx_log [64];
   logic [31:0] cmem [64];

   function automatic logic [31:0] word_at(input int idx);
      return 32'hA500_0000 ^ (idx * 32'h0103_0507);
   endfunction

   aud_dma_chan #(.ADDR_W(32), .CNT_W(16), .CHUNK_BYTES(16), .PLAYBACK(1)) i_aud_dma_chan (
      .clk(clk), .rst_n(rst_n), .chan_en(en), .ld_stb(ld_stb), .ld_addr(ld_addr),
      .ld_count(ld_count), .svc_req(svc_req), .svc_avail(svc_avail),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .snk_valid(snk_valid), .snk_data(snk_data),
      .snk_ready(snk_ready), .src_valid(1'b0), .src_data(32'h0), .src_ready(p_src_ready),
      .busy(busy), .cur_addr(cur_addr), .cur_count(cur_count), .done_irq(done_irq));

   aud_dma_chan #(.ADDR_W(32), .CNT_W(16), .CHUNK_BYTES(16), .PLAYBACK(0)) i_aud_dma_chan_cap (
      .clk(clk), .rst_n(rst_n), .chan_en(en), .ld_stb(c_ld), .ld_addr(c_ld_addr),
      .ld_count(c_ld_count), .svc_req(c_svc), .svc_avail(c_avail),
      .mem_req(c_mem_req), .mem_we(c_mem_we), .mem_addr(c_mem_addr), .mem_wdata(c_mem_wdata),
      .mem_gnt(c_mem_gnt), .mem_rdata(32'h0), .snk_valid(c_unused_valid), .snk_data(c_unused_data),
      .snk_ready(1'b0), .src_valid(c_src_on), .src_data(c_src_data), .src_ready(c_src_ready),
      .busy(c_busy), .cur_addr(c_addr), .cur_count(c_count), .done_irq(c_irq));

   // memory and stream models
   assign mem_gnt    = mem_req & gnt_tog;
   assign c_mem_gnt  = c_mem_req & gnt_tog;
   assign mem_rdata  = word_at(int'(mem_addr[7:2]));
   assign c_src_data = 32'hC0DE_0000 + c_k;
   assign snk_ready  = (snk_mode == 0) ? 1'b1 :
                       (snk_mode == 1) ? (rx_n < rx_lim) :
                       (snk_mode == 2) ? (hold == 0) : 1'b0;

   always @(posedge clk) begin
      gnt_tog <= ~gnt_tog;
      cyc <= cyc + 1;
      if (done_irq) irq_cnt <= irq_cnt + 1;
      if (c_irq) c_irq_cnt <= c_irq_cnt + 1;
      if (c_mem_req && c_mem_we && c_mem_gnt) cmem[c_mem_addr[7:2]] <= c_mem_wdata;
      if (c_src_on && c_src_ready) c_k <= c_k + 1;
      if (snk_valid && snk_ready) begin
         rx_log[rx_n % 64] <= snk_data;
         rx_n <= rx_n + 1;
         if (snk_mode == 2 && rx_n == stall_at) hold <= 8;
      end else if (hold != 0) begin
         hold <= hold - 1;
      end
      if (cyc == 100000) begin
         n_fail++;
         $display("FAIL watchdog: got cycle %0d expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load(input bit cap, input logic [31:0] a, input logic [15:0] n);
      @(negedge clk);
      if (cap) begin c_ld = 1; c_ld_addr = a; c_ld_count = n; end
      else begin ld_stb = 1; ld_addr = a; ld_count = n; end
      @(negedge clk);
      c_ld = 0; ld_stb = 0;
   endtask

   task automatic service(input bit cap, input logic [15:0] av);
      if (cap) begin c_svc = 1; c_avail = av; end
      else begin svc_req = 1; svc_avail = av; end
      @(negedge clk);
      c_svc = 0; svc_req = 0;
   endtask

   task automatic wait_idle(input bit cap);
      int n = 0;
      while ((cap ? c_busy : busy) && n < 2000) begin @(negedge clk); n++; end
      chk(n < 2000, "pass end", 64'(n), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   typedef struct packed {
      logic [31:0] addr;
      logic [15:0] cnt;
      logic [15:0] av;
      logic [15:0] moved;
      logic        irq;
   } vec_t;

   // address, count, offer, expected bytes moved, expected interrupt
   localparam vec_t VECS [7] = '{
      '{32'h0000_0000, 16'd16, 16'd64,  16'd16, 1'b1},
      '{32'h0000_0020, 16'd40, 16'd24,  16'd24, 1'b0},
      '{32'h0000_0080, 16'd20, 16'd20,  16'd20, 1'b1},
      '{32'h0000_004B, 16'd14, 16'd100, 16'd12, 1'b1},
      '{32'h0000_0100, 16'd32, 16'd3,   16'd0,  1'b0},
      '{32'h0000_0010, 16'd8,  16'd0,   16'd0,  1'b0},
      '{32'h0000_00C0, 16'd36, 16'd100, 16'd36, 1'b1}
   };

   initial begin
      int rx0, irq0, errs;
      logic [31:0] base;
      rst_n = 0; en = 1; ld_stb = 0; svc_req = 0; ld_addr = 0; ld_count = 0; svc_avail = 0;
      c_ld = 0; c_svc = 0; c_src_on = 1; c_ld_addr = 0; c_ld_count = 0; c_avail = 0;
      for (int i = 0; i < 64; i++) begin cmem[i] = 32'h0; rx_log[i] = 32'h0; end
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done_irq && !mem_req && !snk_valid, "R1 idle outputs",
          {busy, done_irq, mem_req, snk_valid}, 4'h0);
      chk(cur_count == 0 && cur_addr == 0, "R1 pointers", {cur_addr, 16'h0, cur_count}, 64'h0);
      chk(!c_busy && !c_src_ready && !c_mem_req, "R1 capture idle", {c_busy, c_src_ready, c_mem_req}, 3'h0);

      // table walk: R3 budget, R5 chunking (vector 6 spans three chunks), R7, R8
      for (int v = 0; v < 7; v++) begin
         rx0 = rx_n; irq0 = irq_cnt;
         base = {VECS[v].addr[31:2], 2'b00};
         load(0, VECS[v].addr, VECS[v].cnt);
         service(0, VECS[v].av);
         wait_idle(0);
         chk(cur_count == {VECS[v].cnt[15:2], 2'b00} - VECS[v].moved, "R3 remaining count",
             cur_count, {VECS[v].cnt[15:2], 2'b00} - VECS[v].moved);
         chk(cur_addr == base + VECS[v].moved, "R7 address advance", cur_addr, base + VECS[v].moved);
         chk(rx_n - rx0 == VECS[v].moved / 4, "R3 words moved", rx_n - rx0, VECS[v].moved / 4);
         errs = 0;
         for (int k = 0; k < VECS[v].moved / 4; k++)
            if (rx_log[(rx0 + k) % 64] !== word_at((int'(base >> 2) + k) % 64)) errs++;
         chk(errs == 0, "R7 stream data order", errs, 0);
         chk(irq_cnt - irq0 == VECS[v].irq, "R8 completion pulse", irq_cnt - irq0, VECS[v].irq);
      end

      // R4 / R8: count already zero, no pass and no repeated interrupt
      irq0 = irq_cnt;
      service(0, 16'd64);
      chk(!busy, "R4 zero count no pass", busy, 0);
      wait_idle(0);
      chk(irq_cnt == irq0, "R8 no repeat at zero", irq_cnt - irq0, 0);

      // R4: disabled channel ignores service
      en = 0;
      load(0, 32'h40, 16'd16);
      service(0, 16'd16);
      chk(!busy && !mem_req, "R4 disabled no request", {busy, mem_req}, 0);
      wait_idle(0);
      chk(cur_count == 16, "R4 disabled count kept", cur_count, 16);
      en = 1;

      // R5: sink not ready at first chunk
      snk_mode = 3; rx0 = rx_n; irq0 = irq_cnt;
      load(0, 32'h40, 16'd16);
      service(0, 16'd16);
      wait_idle(0);
      chk(cur_count == 16 && rx_n == rx0, "R5 refused at start", {cur_count, 32'(rx_n - rx0)}, 64'h10_0000_0000);
      chk(irq_cnt == irq0, "R5 no pulse on refusal", irq_cnt - irq0, 0);

      // R5: sink refuses at second chunk start
      snk_mode = 1; rx_lim = rx_n + 4; rx0 = rx_n; irq0 = irq_cnt;
      load(0, 32'h40, 16'd48);
      service(0, 16'd48);
      wait_idle(0);
      chk(cur_count == 32 && cur_addr == 32'h50, "R5 partial pass kept", {cur_count, cur_addr}, {16'd32, 32'h50});
      chk(rx_n - rx0 == 4 && irq_cnt == irq0, "R5 one chunk no pulse", {32'(rx_n - rx0), 32'(irq_cnt - irq0)}, {32'd4, 32'd0});

      // R6: stall inside a chunk waits
      snk_mode = 2; stall_at = rx_n + 1; rx0 = rx_n; irq0 = irq_cnt;
      load(0, 32'h40, 16'd16);
      service(0, 16'd16);
      wait_idle(0);
      chk(cur_count == 0 && rx_n - rx0 == 4, "R6 stall completes chunk", {cur_count, 32'(rx_n - rx0)}, {16'd0, 32'd4});
      chk(irq_cnt - irq0 == 1, "R6 pulse after stall", irq_cnt - irq0, 1);

      // R9: enable cleared after the second word
      snk_mode = 0; rx0 = rx_n; irq0 = irq_cnt;
      load(0, 32'h80, 16'd32);
      service(0, 16'd32);
      while (rx_n < rx0 + 2) @(negedge clk);
      en = 0;
      wait_idle(0);
      chk(cur_count == 20 && cur_addr == 32'h8C, "R9 in-flight word completes", {cur_count, cur_addr}, {16'd20, 32'h8C});
      chk(irq_cnt == irq0, "R9 no pulse when disabled", irq_cnt - irq0, 0);
      en = 1;

      // R2 / R13: load and service during a pass are ignored
      irq0 = irq_cnt;
      load(0, 32'h0, 16'd32);
      svc_req = 1; svc_avail = 16'd8;
      @(negedge clk);
      svc_req = 1; svc_avail = 16'd100; ld_stb = 1; ld_count = 16'd4; ld_addr = 32'h20;
      @(negedge clk);
      svc_req = 0; ld_stb = 0;
      wait_idle(0);
      chk(cur_count == 24, "R2 R13 busy load and service ignored", cur_count, 24);
      chk(cur_addr == 32'h8, "R13 address after single pass", cur_addr, 32'h8);

      // R12: capture writes source words to ascending memory
      c_src_on = 1; irq0 = c_irq_cnt; rx0 = c_k;
      load(1, 32'h20, 16'd12);
      service(1, 16'd100);
      wait_idle(1);
      errs = 0;
      for (int k = 0; k < 3; k++)
         if (cmem[8 + k] !== 32'hC0DE_0000 + 32'(rx0 + k)) errs++;
      chk(errs == 0, "R12 capture data", errs, 0);
      chk(c_count == 0 && c_irq_cnt - irq0 == 1, "R12 capture done pulse", {c_count, 32'(c_irq_cnt - irq0)}, {16'd0, 32'd1});

      // R5: capture source not valid
      c_src_on = 0; irq0 = c_irq_cnt;
      load(1, 32'h40, 16'd8);
      service(1, 16'd8);
      wait_idle(1);
      chk(c_count == 8 && c_irq_cnt == irq0, "R5 capture refused", {c_count, 32'(c_irq_cnt - irq0)}, {16'd8, 32'd0});

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule